// File: doc/BRIEF.md
# Prioritized Interrupt Selection Unit

This block decides, once per clock, whether the hart should take an interrupt trap and which one. It combines the pending and enable vectors with the delegation mask, the current privilege level and the two global interrupt enables. Machine-level candidates are resolved first. Supervisor-level candidates, meaning the delegated bits, are consulted only when no machine-level candidate exists. A fixed class order is then applied, followed by a lowest-bit pick inside the winning class.

The result is registered. `take_o` shows that a trap is due for the inputs of the previous cycle, and `cause_o` carries the interrupt marker in its top bit together with the chosen bit index. A stall input freezes both outputs so that a trap-entry stage that is busy sees a steady request. Debug mode suppresses every take.

Top module: `irq_select`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `take_o` is 0 and `cause_o` is all zeros.
- R2: A bit whose delegation bit is 0 is a machine candidate when its pending and enable bits are both 1 and the privilege is not 3, or the privilege is 3 with `mie_i` = 1. Privilege codes are 0 user, 1 supervisor, 2 reserved, 3 machine.
- R3: A bit whose delegation bit is 1 is a supervisor candidate when its pending and enable bits are both 1 and either the privilege is 0, or the privilege is 1 with `sie_i` = 1. Privilege 2 or 3 never enables a supervisor candidate.
- R4: Supervisor candidates are considered only when there is no machine candidate, even if the supervisor bit would win on class.
- R5: While `debug_i` is 1, no interrupt is taken.
- R6: Candidate bits at index 12 and above outrank every other class. The lowest such index is selected.
- R7: Below that class, the order is external (bits 11 and 9), then software (bits 3 and 1), then timer (bits 7 and 5). Within the winning class, the lower index is chosen.
- R8: When a take occurs, `cause_o[XLEN-1]` is 1, the low bits hold the selected index, and all other bits are 0.
- R9: Candidates at bit indices 0, 2, 4, 6, 8 and 10 belong to no class. They never cause a take on their own.
- R10: When `stall_i` is 0, the outputs reflect the inputs sampled at the previous rising edge. When `stall_i` is 1, both outputs keep their values.
- R11: When no interrupt is taken, `cause_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NIRQ | Pending interrupt bits |
| en_i | input | NIRQ | Per-interrupt enable bits |
| deleg_i | input | NIRQ | 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| debug_i | input | 1 | Hart is in debug mode |
| stall_i | input | 1 | Hold the output stage |
| take_o | output | 1 | Interrupt trap is due |
| cause_o | output | XLEN | Trap cause: interrupt marker plus index |

## Verification
Every result is due exactly one rising edge after its inputs. The bench therefore drives each vector on a falling edge and compares on the next falling edge, after the single register stage has updated. For a stall, the bench first applies a vector that produces a take. It then changes the inputs with `stall_i` high and expects the earlier outputs one edge later. After releasing the stall, it expects the new vector's result on the following edge. A sweep over generated vectors covers every privilege and global-enable combination with sparse pending patterns, compared against an arithmetic model.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;
    localparam int unsigned BIT_SSW  = 1;
    localparam int unsigned BIT_MSW  = 3;
    localparam int unsigned BIT_STMR = 5;
    localparam int unsigned BIT_MTMR = 7;
    localparam int unsigned BIT_SEXT = 9;
    localparam int unsigned BIT_MEXT = 11;
    localparam int unsigned FIRST_CUSTOM = BIT_MEXT + 1;

    localparam logic [1:0] PRV_USER  = 2'd0;
    localparam logic [1:0] PRV_SUPER = 2'd1;
    localparam logic [1:0] PRV_MACH  = 2'd3;
endpackage

// File: rtl/irq_elig.sv
module irq_elig
    import irq_select_pkg::*;
#(
    parameter int unsigned NIRQ = 16
) (
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            debug_i,
    output logic [NIRQ-1:0] cand_o
);
    logic            m_on;
    logic            s_on;
    logic [NIRQ-1:0] live;
    logic [NIRQ-1:0] m_set;
    logic [NIRQ-1:0] s_set;

    always_comb begin
        m_on  = (priv_i != PRV_MACH) || mie_i;
        s_on  = (priv_i == PRV_USER) || ((priv_i == PRV_SUPER) && sie_i);
        live  = pend_i & en_i;
        m_set = m_on ? (live & ~deleg_i) : '0;
        s_set = s_on ? (live & deleg_i) : '0;
        if (debug_i)
            cand_o = '0;
        else if (m_set != '0)
            cand_o = m_set;
        else
            cand_o = s_set;
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_select_pkg::*;
#(
    parameter int unsigned NIRQ = 16,
    localparam int unsigned IDXW = $clog2(NIRQ)
) (
    input  logic [NIRQ-1:0] cand_i,
    output logic            found_o,
    output logic [IDXW-1:0] idx_o
);
    localparam logic [NIRQ-1:0] ONE = NIRQ'(1);
    localparam logic [NIRQ-1:0] CUSTOM_M = {NIRQ{1'b1}} << FIRST_CUSTOM;
    localparam logic [NIRQ-1:0] EXT_M = (ONE << BIT_MEXT) | (ONE << BIT_SEXT);
    localparam logic [NIRQ-1:0] SW_M  = (ONE << BIT_MSW)  | (ONE << BIT_SSW);
    localparam logic [NIRQ-1:0] TMR_M = (ONE << BIT_MTMR) | (ONE << BIT_STMR);

    logic [NIRQ-1:0] grp;

    always_comb begin
        if ((cand_i & CUSTOM_M) != '0)
            grp = cand_i & CUSTOM_M;
        else if ((cand_i & EXT_M) != '0)
            grp = cand_i & EXT_M;
        else if ((cand_i & SW_M) != '0)
            grp = cand_i & SW_M;
        else
            grp = cand_i & TMR_M;

        found_o = (grp != '0);
        idx_o   = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (grp[i])
                idx_o = IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_select_pkg::*;
#(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NIRQ = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] pend_i,
    input  logic [NIRQ-1:0] en_i,
    input  logic [NIRQ-1:0] deleg_i,
    input  logic [1:0]      priv_i,
    input  logic            mie_i,
    input  logic            sie_i,
    input  logic            debug_i,
    input  logic            stall_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o
);
    localparam int unsigned IDXW = $clog2(NIRQ);

    typedef struct packed {
        logic            take;
        logic [XLEN-1:0] cause;
    } out_t;

    logic [NIRQ-1:0] cand;
    logic            found;
    logic [IDXW-1:0] idx;
    out_t            st_d;
    out_t            st_q;

    irq_elig #(.NIRQ(NIRQ)) u_elig (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .deleg_i (deleg_i),
        .priv_i  (priv_i),
        .mie_i   (mie_i),
        .sie_i   (sie_i),
        .debug_i (debug_i),
        .cand_o  (cand)
    );

    irq_prio #(.NIRQ(NIRQ)) u_prio (
        .cand_i  (cand),
        .found_o (found),
        .idx_o   (idx)
    );

    always_comb begin
        st_d = st_q;
        if (!stall_i) begin
            st_d.take  = found;
            st_d.cause = '0;
            if (found) begin
                st_d.cause[XLEN-1]   = 1'b1;
                st_d.cause[IDXW-1:0] = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign take_o  = st_q.take;
    assign cause_o = st_q.cause;
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned NIRQ = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NIRQ-1:0] pend_i,
    input logic [NIRQ-1:0] en_i,
    input logic            debug_i,
    input logic            stall_i,
    input logic            take_o,
    input logic [XLEN-1:0] cause_o
);
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> ($stable(take_o) && $stable(cause_o))); // R10
    AST_DEBUG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && debug_i) |=> !take_o); // R5
    AST_CAUSE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> cause_o[XLEN-1]); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0)); // R11
    AST_NO_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_i && ((pend_i & en_i) == '0)) |=> !take_o); // R2
endmodule

bind irq_select irq_select_chk #(.XLEN(XLEN), .NIRQ(NIRQ)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_i  (pend_i),
    .en_i    (en_i),
    .debug_i (debug_i),
    .stall_i (stall_i),
    .take_o  (take_o),
    .cause_o (cause_o)
);

// File: tb/tb_irq_select.sv
module tb_irq_select;
    localparam int XLEN = 32;
    localparam int NIRQ = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NIRQ-1:0] pend = '0, en = '0, deleg = '0;
    logic [1:0]      priv = 2'd3;
    logic            mie = 1'b0, sie = 1'b0, dbg = 1'b0, stall = 1'b0;
    logic            take_o;
    logic [XLEN-1:0] cause_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #2 clk = ~clk;

    irq_select #(.XLEN(XLEN), .NIRQ(NIRQ)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
        .priv_i(priv), .mie_i(mie), .sie_i(sie), .debug_i(dbg), .stall_i(stall),
        .take_o(take_o), .cause_o(cause_o)
    );

    function automatic int low_in(input logic [NIRQ-1:0] v, input logic [NIRQ-1:0] m);
        for (int i = 0; i < NIRQ; i++)
            if (v[i] && m[i]) return i;
        return -1;
    endfunction

    function automatic logic [XLEN:0] model(
        input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e, input logic [NIRQ-1:0] d,
        input logic [1:0] pv, input logic m, input logic s, input logic db);
        logic [NIRQ-1:0] c;
        int k;
        logic [XLEN-1:0] cz;
        c = p & e & ~d;
        if (pv == 2'd3 && !m) c = '0;
        if (c == '0) begin
            c = p & e & d;
            if (!(pv == 2'd0 || (pv == 2'd1 && s))) c = '0;
        end
        if (db) c = '0;
        k = low_in(c, 16'hF000);
        if (k < 0) k = low_in(c, 16'h0A00);
        if (k < 0) k = low_in(c, 16'h000A);
        if (k < 0) k = low_in(c, 16'h00A0);
        if (k < 0) return '0;
        cz = '0;
        cz[XLEN-1] = 1'b1;
        cz = cz | XLEN'(k);
        return {1'b1, cz};
    endfunction

    task automatic cmp(input string tag, input logic et, input logic [XLEN-1:0] ec);
        checks++;
        if (take_o !== et || cause_o !== ec) begin
            errors++;
            $display("FAIL %s: take=%0b cause=%h expected take=%0b cause=%h",
                     tag, take_o, cause_o, et, ec);
        end
    endtask

    task automatic apply(input string tag, input logic [NIRQ-1:0] p, input logic [NIRQ-1:0] e,
                         input logic [NIRQ-1:0] d, input logic [1:0] pv,
                         input logic m, input logic s, input logic db);
        logic [XLEN:0] x;
        @(negedge clk);
        pend = p; en = e; deleg = d; priv = pv; mie = m; sie = s; dbg = db; stall = 1'b0;
        x = model(p, e, d, pv, m, s, db);
        @(negedge clk);
        cmp(tag, x[XLEN], x[XLEN-1:0]);
    endtask

    function automatic logic [XLEN-1:0] cz(input int k);
        return {1'b1, {(XLEN-1){1'b0}}} | XLEN'(k);
    endfunction

    initial begin : wdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1 reset", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        cmp("R1 after reset", 1'b0, '0);

        apply("R2 machine at M with mie", 16'h0080, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0);
        cmp("R2 mtimer cause", 1'b1, cz(7));
        apply("R2 M blocked without mie", 16'h0080, 16'hFFFF, 16'h0, 2'd3, 0, 0, 0);
        cmp("R11 zero cause", 1'b0, '0);
        apply("R2 below M ignores mie", 16'h0008, 16'hFFFF, 16'h0, 2'd1, 0, 0, 0);
        cmp("R2 msw cause", 1'b1, cz(3));
        apply("R3 S at U", 16'h0020, 16'hFFFF, 16'h0020, 2'd0, 0, 0, 0);
        cmp("R3 stimer", 1'b1, cz(5));
        apply("R3 S at S without sie", 16'h0020, 16'hFFFF, 16'h0020, 2'd1, 1, 0, 0);
        cmp("R3 blocked", 1'b0, '0);
        apply("R3 S at M never", 16'h0020, 16'hFFFF, 16'h0020, 2'd3, 1, 1, 0);
        cmp("R3 blocked at M", 1'b0, '0);
        apply("R4 machine timer beats S external", 16'h0280, 16'hFFFF, 16'h0200, 2'd0, 1, 1, 0);
        cmp("R4 cause", 1'b1, cz(7));
        apply("R5 debug blocks", 16'h0800, 16'hFFFF, 16'h0, 2'd0, 1, 1, 1);
        cmp("R5 none", 1'b0, '0);
        apply("R6 custom beats external", 16'hA800, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0);
        cmp("R6 lowest custom", 1'b1, cz(13));
        apply("R7 ext beats sw", 16'h020A, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0);
        cmp("R7 sext", 1'b1, cz(9));
        apply("R7 sw beats timer", 16'h00A8, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0);
        cmp("R7 msw", 1'b1, cz(3));
        apply("R9 unclassed only", 16'h0555, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0);
        cmp("R9 none", 1'b0, '0);
        apply("R8 enable masks", 16'h8000, 16'h7FFF, 16'h0, 2'd3, 1, 0, 0);
        cmp("R8 masked none", 1'b0, '0);

        apply("R10 pre-stall", 16'h0800, 16'hFFFF, 16'h0, 2'd3, 1, 0, 0);
        @(negedge clk);
        pend = 16'h0002; stall = 1'b1;
        @(negedge clk);
        cmp("R10 held under stall", 1'b1, cz(11));
        stall = 1'b0;
        @(negedge clk);
        cmp("R10 update after release", 1'b1, cz(1));

        for (int n = 0; n < 2000; n++) begin
            logic [NIRQ-1:0] p, e, d;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            p = rng[15:0] & rng[31:16];
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            e = rng[15:0] | rng[31:16];
            d = rng[23:8];
            for (int c = 0; c < 16; c++)
                apply("R2 R3 R4 R6 R7 R8 sweep", p, e, d, c[1:0], c[2], c[3], (n % 8) == 7);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule